// File: doc/BRIEF.md
# Configuration Access PIO Engine

This block lets software issue a single configuration-space read or write toward a downstream link, one at a time, through a small 32-bit register bus. Software first fills in a transaction-type code, a 64-bit target address, write data and byte strobes. It then writes 1 to the start bit. The engine takes a copy of those fields and presents one request on a valid/ready port. After the request is accepted, it waits for a completion that carries a 3-bit status and read data.

When the completion arrives, the start bit drops back to 0. The status is captured, and read data is captured if the transaction was a read. A sticky done flag is set. Software treats a transaction as finished only when the start bit reads 0 and the done register is non-zero. It clears done by writing 1 to it.

The low address word is laid out as bus[27:20], device[19:15], function[14:12] and register offset[11:0]. Software picks type 0 when the target bus is directly below the bridge and type 1 for buses further down. The engine forwards the address unchanged. The link, framing and retries belong to the completer on the far side of the request port.

Top module: `cfg_pio_engine`

Register word indices on `bus_addr`:
- 0: start, bit 0
- 1: done, bit 0, write 1 to clear
- 2: control, type code in bits 3:0
- 3: status, completion status in bits 9:7
- 4: address low
- 5: address high
- 6: write data
- 7: byte strobe, bits 3:0
- 8: read data

## Requirements
- R1: After reset, every register reads 0 and `req_valid` is 0.
- R2: The type code in control bits 3:0 sets the request kind. Bit 1 selects write (`req_write`) and bit 0 selects type 1 (`req_type1`). So 0x8 is a type-0 read, 0x9 a type-1 read, 0xA a type-0 write and 0xB a type-1 write.
- R3: Writing 1 to bit 0 of word 0 while idle launches a transaction, and `req_valid` is 1 in the cycle after the write. The request carries `req_addr` = {address high, address low}, the write data and strobe bits 3:0. Word 0 then reads 1.
- R4: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and the request fields stay stable. `req_valid` is 0 in the cycle after the handshake.
- R5: A `cpl_valid` pulse is consumed only after the handshake. In the following cycle, word 0 reads 0, word 1 reads 1 and word 3 bits 9:7 hold `cpl_status`.
- R6: A read completion (type bit 1 = 0) loads `cpl_data` into word 8. A write completion leaves word 8 unchanged.
- R7: The status field keeps its value until the next launch, and a launch resets it to 0.
- R8: Writing 1 to bit 0 of word 1 clears done, and writing 0 leaves it set. When a clear and a completion fall in the same cycle, done ends up set.
- R9: A start write while a transaction is in flight is ignored. Register writes made during that time update the registers but do not change the request being issued.
- R10: Writing 0 to word 0 while a transaction is in flight stops it. `req_valid` drops, word 0 reads 0, and a later completion is discarded: done, status and read data do not change.
- R11: Control and strobe read back only their low 4 bits, with the upper bits 0. The address and write-data words read back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write enable |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by completer |
| req_write | output | 1 | 1 = write, 0 = read |
| req_type1 | output | 1 | 1 = type-1 configuration cycle |
| req_addr | output | 64 | Target address {high, low} |
| req_wdata | output | 32 | Write data |
| req_strb | output | 4 | Write byte strobes |
| cpl_valid | input | 1 | Completion strobe |
| cpl_status | input | 3 | Completion status |
| cpl_data | input | 32 | Completion read data |

## Verification
The bench sweeps all four type codes across ready and completion delays of 0 to 3 cycles and all eight status values. A wrong type decode would show as a swapped `req_write` or `req_type1`. A sequencer that dropped `req_valid` early would show up during the ready wait. It also checks that write completions leave the read-data word alone, since a capture keyed on any completion would overwrite it.

The bench retriggers start and rewrites the registers mid-flight. A design without a snapshot would send a changed address, and one that accepted the retrigger would send a second request. Stopping before and after acceptance must leave done, status and read data untouched by a stray completion. A clear that lands in the same cycle as a completion must lose, or software would miss a finished transaction.

// File: rtl/cfgpio_pkg.sv
`timescale 1ns/1ps
package cfgpio_pkg;

  localparam int REG_IDX_W = 4;
  localparam int TYPE_W    = 4;
  localparam int CPL_W     = 3;
  localparam int STAT_LSB  = 7;

  typedef enum logic [REG_IDX_W-1:0] {
    RI_START   = 4'd0,
    RI_DONE    = 4'd1,
    RI_CTRL    = 4'd2,
    RI_STAT    = 4'd3,
    RI_ADDR_LO = 4'd4,
    RI_ADDR_HI = 4'd5,
    RI_WDATA   = 4'd6,
    RI_STRB    = 4'd7,
    RI_RDATA   = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic write;
    logic type1;
  } xact_kind_t;

  // bit 1 of the code picks direction, bit 0 picks the cycle type
  function automatic xact_kind_t decode_kind(input logic [TYPE_W-1:0] code);
    xact_kind_t k;
    k.write = code[1];
    k.type1 = code[0];
    return k;
  endfunction

  function automatic logic [31:0] place_status(input logic [CPL_W-1:0] s);
    logic [31:0] w;
    w = '0;
    w[STAT_LSB +: CPL_W] = s;
    return w;
  endfunction

endpackage

// File: rtl/cfgpio_regs.sv
`timescale 1ns/1ps
module cfgpio_regs
  import cfgpio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen,
  input  logic [REG_IDX_W-1:0] widx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [TYPE_W-1:0]    type_q,
  output logic [DATA_W-1:0]    addr_lo_q,
  output logic [DATA_W-1:0]    addr_hi_q,
  output logic [DATA_W-1:0]    wdata_q,
  output logic [STRB_W-1:0]    strb_q,
  output logic                 start_wr,
  output logic                 start_val,
  output logic                 done_clr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q    <= '0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      wdata_q   <= '0;
      strb_q    <= '0;
    end else if (wen) begin
      case (widx)
        RI_CTRL:    type_q    <= wdata[TYPE_W-1:0];
        RI_ADDR_LO: addr_lo_q <= wdata;
        RI_ADDR_HI: addr_hi_q <= wdata;
        RI_WDATA:   wdata_q   <= wdata;
        RI_STRB:    strb_q    <= wdata[STRB_W-1:0];
        default: ;
      endcase
    end
  end

  // command pulses for the sequencer and the done flag
  assign start_wr  = wen && (widx == RI_START);
  assign start_val = wdata[0];
  assign done_clr  = wen && (widx == RI_DONE) && wdata[0];

endmodule

// File: rtl/cfgpio_seq.sv
`timescale 1ns/1ps
module cfgpio_seq
  import cfgpio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8,
  localparam int RA_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_val,
  input  xact_kind_t        kind,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] addr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] strb,
  input  logic              req_ready,
  input  logic              cpl_valid,
  output logic              req_valid,
  output logic              req_write,
  output logic              req_type1,
  output logic [RA_W-1:0]   req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [STRB_W-1:0] req_strb,
  output logic              busy,
  output logic              launch_evt,
  output logic              accept_evt,
  output logic              finish_evt,
  output logic              abort_evt
);

  seq_state_e state_q;
  xact_kind_t kind_s;
  logic [RA_W-1:0]   addr_s;
  logic [DATA_W-1:0] wdata_s;
  logic [STRB_W-1:0] strb_s;

  assign busy       = (state_q != SQ_IDLE);
  assign req_valid  = (state_q == SQ_REQ);
  assign launch_evt = start_wr && start_val && !busy;
  assign abort_evt  = start_wr && !start_val && busy;
  assign accept_evt = req_valid && req_ready;
  assign finish_evt = (state_q == SQ_WAIT) && cpl_valid && !abort_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      kind_s  <= '0;
      addr_s  <= '0;
      wdata_s <= '0;
      strb_s  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (launch_evt) state_q <= SQ_REQ;
        SQ_REQ: begin
          if (abort_evt)       state_q <= SQ_IDLE;
          else if (accept_evt) state_q <= SQ_WAIT;
        end
        SQ_WAIT: if (abort_evt || finish_evt) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
      if (launch_evt) begin
        kind_s  <= kind;
        addr_s  <= {addr_hi, addr_lo};
        wdata_s <= wdata;
        strb_s  <= strb;
      end
    end
  end

  assign req_write = kind_s.write;
  assign req_type1 = kind_s.type1;
  assign req_addr  = addr_s;
  assign req_wdata = wdata_s;
  assign req_strb  = strb_s;

endmodule

// File: rtl/cfgpio_capture.sv
`timescale 1ns/1ps
module cfgpio_capture
  import cfgpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_evt,
  input  logic              finish_evt,
  input  logic              is_write,
  input  logic              done_clr,
  input  logic [CPL_W-1:0]  cpl_status,
  input  logic [DATA_W-1:0] cpl_data,
  output logic [CPL_W-1:0]  status_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      if (launch_evt)      status_q <= '0;
      else if (finish_evt) status_q <= cpl_status;

      if (finish_evt && !is_write) rdata_q <= cpl_data;

      // a completion in the same cycle as a clear wins
      if (finish_evt)    done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_pio_engine.sv
`timescale 1ns/1ps
module cfg_pio_engine
  import cfgpio_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int RA_W   = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wen,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic                 req_write,
  output logic                 req_type1,
  output logic [RA_W-1:0]      req_addr,
  output logic [DATA_W-1:0]    req_wdata,
  output logic [STRB_W-1:0]    req_strb,
  input  logic                 cpl_valid,
  input  logic [CPL_W-1:0]     cpl_status,
  input  logic [DATA_W-1:0]    cpl_data
);

  logic [TYPE_W-1:0] type_q;
  logic [DATA_W-1:0] addr_lo_q, addr_hi_q, wdata_q, rdata_q;
  logic [STRB_W-1:0] strb_q;
  logic [CPL_W-1:0]  status_q;
  logic start_wr, start_val, done_clr, done_q, busy;
  logic launch_evt, accept_evt, finish_evt, abort_evt;
  xact_kind_t kind;

  assign kind = decode_kind(type_q);

  cfgpio_regs #(.DATA_W(DATA_W), .STRB_W(STRB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .widx(bus_addr), .wdata(bus_wdata),
    .type_q(type_q), .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q),
    .wdata_q(wdata_q), .strb_q(strb_q),
    .start_wr(start_wr), .start_val(start_val), .done_clr(done_clr)
  );

  cfgpio_seq #(.DATA_W(DATA_W), .STRB_W(STRB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_val(start_val),
    .kind(kind), .addr_lo(addr_lo_q), .addr_hi(addr_hi_q), .wdata(wdata_q),
    .strb(strb_q), .req_ready(req_ready), .cpl_valid(cpl_valid),
    .req_valid(req_valid), .req_write(req_write), .req_type1(req_type1),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .busy(busy), .launch_evt(launch_evt), .accept_evt(accept_evt),
    .finish_evt(finish_evt), .abort_evt(abort_evt)
  );

  cfgpio_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .launch_evt(launch_evt), .finish_evt(finish_evt),
    .is_write(req_write), .done_clr(done_clr), .cpl_status(cpl_status),
    .cpl_data(cpl_data), .status_q(status_q), .rdata_q(rdata_q), .done_q(done_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RI_START:   bus_rdata[0] = busy;
      RI_DONE:    bus_rdata[0] = done_q;
      RI_CTRL:    bus_rdata[TYPE_W-1:0] = type_q;
      RI_STAT:    bus_rdata = place_status(status_q);
      RI_ADDR_LO: bus_rdata = addr_lo_q;
      RI_ADDR_HI: bus_rdata = addr_hi_q;
      RI_WDATA:   bus_rdata = wdata_q;
      RI_STRB:    bus_rdata[STRB_W-1:0] = strb_q;
      RI_RDATA:   bus_rdata = rdata_q;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgpio_checker.sv
`timescale 1ns/1ps
module cfgpio_checker
  import cfgpio_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int RA_W   = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch_evt,
  input logic              finish_evt,
  input logic              abort_evt,
  input logic              done_clr,
  input logic              busy,
  input logic              done_q,
  input logic [CPL_W-1:0]  status_q,
  input logic [DATA_W-1:0] rdata_q,
  input logic [TYPE_W-1:0] type_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_type1,
  input logic [RA_W-1:0]   req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [STRB_W-1:0] req_strb,
  input logic [CPL_W-1:0]  cpl_status
);

  AST_TYPE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> (req_write == $past(type_q[1])) && (req_type1 == $past(type_q[0]))); // R2

  AST_LAUNCH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> req_valid); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort_evt) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_strb))); // R4

  AST_FINISH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (done_q && !busy)); // R5

  AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (status_q == $past(cpl_status))); // R5

  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && req_write) |=> $stable(rdata_q)); // R6

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_evt && !finish_evt) |=> $stable(status_q)); // R7

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !finish_evt) |=> !done_q); // R8

  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(req_addr) && $stable(req_wdata) && $stable(req_strb))); // R9

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !req_valid && $stable(done_q) && $stable(rdata_q))); // R10

endmodule

bind cfg_pio_engine cfgpio_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_evt(launch_evt), .finish_evt(finish_evt),
  .abort_evt(abort_evt), .done_clr(done_clr), .busy(busy), .done_q(done_q),
  .status_q(status_q), .rdata_q(rdata_q), .type_q(type_q),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_type1(req_type1), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_strb(req_strb), .cpl_status(cpl_status)
);

// File: tb/sim_cfg_pio_engine.sv
`timescale 1ns/1ps
module sim_cfg_pio_engine;

  localparam logic [3:0] W_START = 4'd0, W_DONE = 4'd1, W_CTRL = 4'd2, W_STAT = 4'd3,
                         W_ALO = 4'd4, W_AHI = 4'd5, W_WD = 4'd6, W_STRB = 4'd7,
                         W_RD = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_write, req_type1;
  logic        req_ready = 1'b0;
  logic [63:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_strb;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_rdata = '0;

  always #2 clk = ~clk;

  cfg_pio_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_type1(req_type1),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  function automatic logic [31:0] cfg_word(input int bus, input int dev, input int fn, input int off);
    return 32'((bus & 255) * (1 << 20) + (dev & 31) * (1 << 15) + (fn & 7) * (1 << 12) + (off & 4095));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.1;
    v = bus_rdata;
  endtask

  task automatic handshake();
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic complete(input logic [2:0] st, input logic [31:0] d);
    @(negedge clk); cpl_valid = 1'b1; cpl_status = st; cpl_data = d;
    @(negedge clk); cpl_valid = 1'b0; cpl_data = 32'hBAD0_BAD0;
  endtask

  task automatic setup(input logic [3:0] code, input logic [31:0] alo, input logic [31:0] wd,
                       input logic [31:0] st);
    wr(W_CTRL, {28'h0, code});
    wr(W_ALO, alo);
    wr(W_AHI, 32'h0);
    wr(W_WD, wd);
    wr(W_STRB, st);
    wr(W_DONE, 32'h1);
  endtask

  task automatic txn(input logic [3:0] code, input logic [31:0] alo, input logic [31:0] wd,
                     input logic [31:0] st, input int rdly, input int cdly,
                     input logic [2:0] cst, input logic [31:0] cdat);
    logic [31:0] v;
    setup(code, alo, wd, st);
    wr(W_START, 32'h1);
    chk("R3 req_valid after start", 64'(req_valid), 64'h1);
    chk("R3 req_addr", req_addr, {32'h0, alo});
    chk("R3 req_wdata", 64'(req_wdata), 64'(wd));
    chk("R3 req_strb", 64'(req_strb), 64'(st[3:0]));
    chk("R2 req_write", 64'(req_write), 64'(code[1]));
    chk("R2 req_type1", 64'(req_type1), 64'(code[0]));
    rd(W_START, v); chk("R3 start reads 1", 64'(v), 64'h1);
    rd(W_STAT, v);  chk("R7 status cleared by launch", 64'(v), 64'h0);
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      chk("R4 valid held", 64'(req_valid), 64'h1);
      chk("R4 addr held", req_addr, {32'h0, alo});
    end
    handshake();
    chk("R4 valid drops after handshake", 64'(req_valid), 64'h0);
    for (int i = 0; i < cdly; i++) @(negedge clk);
    rd(W_START, v); chk("R5 start still 1 awaiting completion", 64'(v), 64'h1);
    rd(W_DONE, v);  chk("R5 done 0 awaiting completion", 64'(v), 64'h0);
    complete(cst, cdat);
    if (!code[1]) exp_rdata = cdat;
    rd(W_START, v); chk("R5 start self-clears", 64'(v), 64'h0);
    rd(W_DONE, v);  chk("R5 done set", 64'(v), 64'h1);
    rd(W_STAT, v);  chk("R5 status captured", 64'(v), 64'(32'(cst) << 7));
    rd(W_RD, v);    chk("R6 read data", 64'(v), 64'(exp_rdata));
    repeat (3) @(negedge clk);
    rd(W_STAT, v);  chk("R7 status holds", 64'(v), 64'(32'(cst) << 7));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      rd(4'(i), v);
      chk("R1 register zero after reset", 64'(v), 64'h0);
    end
    chk("R1 req_valid zero after reset", 64'(req_valid), 64'h0);

    // R11 readback widths
    wr(W_CTRL, 32'hFFFF_FFFF); rd(W_CTRL, v); chk("R11 ctrl readback", 64'(v), 64'hF);
    wr(W_STRB, 32'hFFFF_FFF5); rd(W_STRB, v); chk("R11 strobe readback", 64'(v), 64'h5);
    wr(W_ALO, 32'h1357_9BDF);  rd(W_ALO, v);  chk("R11 addr low readback", 64'(v), 64'h1357_9BDF);
    wr(W_WD, 32'hCAFE_F00D);   rd(W_WD, v);   chk("R11 wdata readback", 64'(v), 64'hCAFE_F00D);

    // R2/R3/R4/R5/R6/R7 sweep over type codes and delays
    for (int c = 8; c < 12; c++) begin
      for (int k = 0; k < 4; k++) begin
        txn(4'(c), cfg_word(c * 29 + k * 61, k * 7 + c, c + k, k * 260 + c * 4),
            32'hA500_0000 ^ 32'(c << 16) ^ 32'(k), (k == 3) ? 32'h3 : 32'hF,
            k, (k + c) % 4, 3'((c + k) % 8), 32'h1234_0000 + 32'(c * 256 + k));
      end
    end
    // every status value on a read
    for (int s = 0; s < 8; s++)
      txn(4'h9, cfg_word(s + 2, s, s, s * 4), 32'h0, 32'hF, s % 2, s % 3, 3'(s), 32'h7700_0000 + 32'(s));

    // R8 done clear semantics (done currently 1)
    wr(W_DONE, 32'h0); rd(W_DONE, v); chk("R8 write 0 keeps done", 64'(v), 64'h1);
    wr(W_DONE, 32'h1); rd(W_DONE, v); chk("R8 write 1 clears done", 64'(v), 64'h0);
    setup(4'h8, cfg_word(1, 0, 0, 0), 32'h0, 32'hF);
    wr(W_START, 32'h1);
    handshake();
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = W_DONE; bus_wdata = 32'h1;
    cpl_valid = 1'b1; cpl_status = 3'd2; cpl_data = 32'h0BAD_CAFE;
    @(negedge clk);
    bus_wen = 1'b0; cpl_valid = 1'b0;
    exp_rdata = 32'h0BAD_CAFE;
    rd(W_DONE, v); chk("R8 completion beats clear", 64'(v), 64'h1);

    // R9 retrigger and register writes in flight
    setup(4'h8, cfg_word(3, 4, 5, 16'h40), 32'h1111_1111, 32'hF);
    wr(W_START, 32'h1);
    wr(W_CTRL, 32'hB);
    wr(W_ALO, cfg_word(9, 9, 1, 12'h80));
    wr(W_WD, 32'h2222_2222);
    wr(W_START, 32'h1);
    chk("R9 addr unchanged in flight", req_addr, {32'h0, cfg_word(3, 4, 5, 16'h40)});
    chk("R9 write flag unchanged", 64'(req_write), 64'h0);
    chk("R9 type1 unchanged", 64'(req_type1), 64'h0);
    chk("R9 wdata unchanged", 64'(req_wdata), 64'h1111_1111);
    rd(W_CTRL, v); chk("R9 ctrl register took new value", 64'(v), 64'hB);
    handshake();
    complete(3'd1, 32'h5151_5151);
    exp_rdata = 32'h5151_5151;
    rd(W_RD, v); chk("R9 read completion of original request", 64'(v), 64'(exp_rdata));
    repeat (3) @(negedge clk);
    chk("R9 no second request", 64'(req_valid), 64'h0);

    // R10 stop before acceptance
    setup(4'h9, cfg_word(7, 1, 1, 8), 32'h0, 32'hF);
    wr(W_START, 32'h1);
    wr(W_START, 32'h0);
    chk("R10 valid dropped on stop", 64'(req_valid), 64'h0);
    rd(W_START, v); chk("R10 start reads 0 after stop", 64'(v), 64'h0);
    // R10 stop after acceptance, completion discarded
    wr(W_START, 32'h1);
    handshake();
    wr(W_START, 32'h0);
    complete(3'd5, 32'hDEAD_0001);
    rd(W_DONE, v); chk("R10 done untouched by stray completion", 64'(v), 64'h0);
    rd(W_STAT, v); chk("R10 status untouched by stray completion", 64'(v), 64'h0);
    rd(W_RD, v);   chk("R10 read data untouched", 64'(v), 64'(exp_rdata));
    rd(W_START, v); chk("R10 start stays 0", 64'(v), 64'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule